// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA channel for programmed-I/O and multiword-DMA data cycles and for task-file register cycles. Each device on the channel has its own 32-bit timing word. The word sets how long the strobe is held active and how long it is held inactive. It also sets a setup delay, which is inserted once before the first cycle of a transfer. Data cycles and task-file (command) cycles use separate fields of the same word.

Software loads a timing word through a small register port. The port accepts a raw write of the whole word. It also accepts a mode-update write, which replaces only the fields that belong to one transfer class. A transfer starts with a single-clock request that carries the cycle kind, the direction, the device and a burst length. The block reports `busy` while the transfer runs and pulses `done` when it is finished. The timing values are captured when the request is accepted. A word rewritten during a transfer therefore affects only later transfers.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset both strobes are high, `busy` and `done` are low, and every timing word reads as zero.
- R2: In a data cycle (`req_cmd`=0) the strobe is low for word[7:4]+1 clocks.
- R3: Between data cycles, and after the last one, the strobe is high for word[3:0]+1 clocks.
- R4: In a command cycle (`req_cmd`=1) the strobe is low for word[15:12]+1 clocks and then high for word[11:8]+1 clocks.
- R5: Before the first strobe, the block waits word[21:19] clocks for a data transfer or word[24:22] clocks for a command transfer. A value of zero means no wait.
- R6: A request performs `req_beats`+1 cycles. The setup wait comes only before the first cycle. Each later active phase follows the previous inactive phase directly.
- R7: A read (`req_wr`=0) pulses only `dior_n` and a write (`req_wr`=1) pulses only `diow_n`. The two strobes are never low at the same time.
- R8: `req_dev` selects the timing word used for a transfer. `cfg_rdata` shows the word selected by `cfg_dev`.
- R9: `cfg_class` 0 stores `cfg_wdata` unchanged. Classes 1 (PIO, mask 0xC1F8FFFF), 2 (MWDMA, mask 0x303800FF) and 3 (UDMA, mask 0x30070000) store (old & ~mask | data & mask) with bits 31:30 cleared.
- R10: A transfer uses the word as it stood when the request was accepted. A write in the accept cycle, or during the transfer, alters only later transfers.
- R11: `done` is high for exactly one clock, directly after the inactive phase of the final cycle. `busy` is high from the clock after acceptance until that point.
- R12: A request raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_dev | input | DW | Device index for a write and for readback |
| cfg_class | input | 2 | Write class: 0 raw, 1 PIO, 2 MWDMA, 3 UDMA |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Timing word of `cfg_dev` |
| req | input | 1 | Transfer request, taken when idle |
| req_cmd | input | 1 | 1 = task-file cycle, 0 = data cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dev | input | DW | Device whose timing word is used |
| req_beats | input | BW | Number of cycles minus one |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |

## Verification
Two functions can fall in the same clock edge: a timing-word write and the acceptance of a request that reads that same word. The bench raises `cfg_we` and `req` together for one device. It then checks that the strobe trace follows the old field values while the readback already shows the new word. A second case rewrites the word halfway through a burst and checks that the burst keeps its original timing. A third case raises a new request in the middle of a burst and checks that the burst's trace is undisturbed.

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
  parameter int NDEV = 2,
  parameter int BW   = 4,
  localparam int DW  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_dev,
  input  logic [1:0]    cfg_class,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req,
  input  logic          req_cmd,
  input  logic          req_wr,
  input  logic [DW-1:0] req_dev,
  input  logic [BW-1:0] req_beats,
  output logic          busy,
  output logic          done,
  output logic          dior_n,
  output logic          diow_n
);
  typedef enum logic [1:0] {IDLE, SETUP, ACT, INACT} st_t;

  st_t          st_q;
  logic [31:0]  word_q [NDEV];
  logic [31:0]  mask, nxt_word, sel;
  logic [3:0]   act_q, ina_q, cnt_q;
  logic [3:0]   a_new, i_new;
  logic [2:0]   s_new;
  logic [BW-1:0] beats_q;
  logic         wr_q, done_q;
  logic         start;

  always_comb begin
    case (cfg_class)
      2'd1:    mask = 32'hC1F8FFFF;
      2'd2:    mask = 32'h303800FF;
      2'd3:    mask = 32'h30070000;
      default: mask = 32'hFFFFFFFF;
    endcase
    nxt_word = (cfg_dev < NDEV) ? word_q[cfg_dev] : 32'h0;
    nxt_word = (nxt_word & ~mask) | (cfg_wdata & mask);
    if (cfg_class != 2'd0) nxt_word[31:30] = 2'b00;
  end

  assign cfg_rdata = (cfg_dev < NDEV) ? word_q[cfg_dev] : 32'h0;
  assign sel       = (req_dev < NDEV) ? word_q[req_dev] : 32'h0;
  assign a_new     = req_cmd ? sel[15:12] : sel[7:4];
  assign i_new     = req_cmd ? sel[11:8]  : sel[3:0];
  assign s_new     = req_cmd ? sel[24:22] : sel[21:19];
  assign start     = req && (st_q == IDLE);

  for (genvar g = 0; g < NDEV; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                         word_q[g] <= 32'h0;
      else if (cfg_we && cfg_dev == DW'(g)) word_q[g] <= nxt_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= IDLE; cnt_q <= '0; act_q <= '0; ina_q <= '0;
      beats_q <= '0; wr_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        IDLE: if (start) begin
          act_q <= a_new; ina_q <= i_new; wr_q <= req_wr; beats_q <= req_beats;
          if (s_new == 3'd0) begin st_q <= ACT;   cnt_q <= a_new; end
          else               begin st_q <= SETUP; cnt_q <= {1'b0, s_new - 3'd1}; end
        end
        SETUP: if (cnt_q == 0) begin st_q <= ACT; cnt_q <= act_q; end
               else cnt_q <= cnt_q - 4'd1;
        ACT:   if (cnt_q == 0) begin st_q <= INACT; cnt_q <= ina_q; end
               else cnt_q <= cnt_q - 4'd1;
        INACT: if (cnt_q != 0) cnt_q <= cnt_q - 4'd1;
               else if (beats_q == 0) begin st_q <= IDLE; done_q <= 1'b1; end
               else begin beats_q <= beats_q - 1'b1; st_q <= ACT; cnt_q <= act_q; end
      endcase
    end
  end

  assign busy   = (st_q != IDLE);
  assign done   = done_q;
  assign dior_n = !((st_q == ACT) && !wr_q);
  assign diow_n = !((st_q == ACT) &&  wr_q);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_inact_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st_q == INACT));
  assert_snapshot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != IDLE) |=> (st_q == IDLE) || ($stable(act_q) && $stable(ina_q) && $stable(wr_q)));
  assert_top_bits_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_class != 2'd0 && cfg_dev < NDEV) |=> word_q[$past(cfg_dev)][31:30] == 2'b00);
endmodule

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, req = 0, req_cmd = 0, req_wr = 0;
  logic [0:0] cfg_dev = 0, req_dev = 0;
  logic [1:0] cfg_class = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [3:0] req_beats = 0;
  logic busy, done, dior_n, diow_n;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pio_strobe_gen u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
    .cfg_class(cfg_class), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
    .req_cmd(req_cmd), .req_wr(req_wr), .req_dev(req_dev), .req_beats(req_beats),
    .busy(busy), .done(done), .dior_n(dior_n), .diow_n(diow_n));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] upd(input logic [31:0] old, input logic [1:0] cls, input logic [31:0] d);
    logic [31:0] m;
    m = (cls == 1) ? 32'hC1F8FFFF : (cls == 2) ? 32'h303800FF : (cls == 3) ? 32'h30070000 : 32'hFFFFFFFF;
    upd = (old & ~m) | (d & m);
    if (cls != 0) upd[31:30] = 2'b00;
  endfunction

  task automatic wr_word(input logic dev, input logic [1:0] cls, input logic [31:0] d);
    cfg_we = 1; cfg_dev = dev; cfg_class = cls; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Caller is at a negedge; request accepted at the next posedge.
  task automatic run(input logic cmd, input logic wr, input logic dev, input logic [3:0] beats,
                     input logic [31:0] w, input string tag);
    int s, a, i, n, p, last, bad, bt;
    logic exp_low, exp_done, act_strobe;
    s = cmd ? int'(w[24:22]) : int'(w[21:19]);
    a = cmd ? int'(w[15:12]) : int'(w[7:4]);
    i = cmd ? int'(w[11:8])  : int'(w[3:0]);
    n = int'(beats) + 1; p = a + i + 2; last = s + n * p + 1;
    bad = 0; bt = 0;
    req = 1; req_cmd = cmd; req_wr = wr; req_dev = dev; req_beats = beats;
    @(negedge clk);
    req = 0; cfg_we = 0;
    for (int t = 1; t <= last + 2; t++) begin
      exp_low  = (t > s) && (t <= s + n * p) && (((t - s - 1) % p) <= a);
      exp_done = (t == last);
      act_strobe = wr ? diow_n : dior_n;
      if (bad == 0 && ((act_strobe !== !exp_low) || ((wr ? dior_n : diow_n) !== 1'b1) ||
                       (done !== exp_done) || (busy !== (t < last)))) begin
        bad = 1; bt = t;
      end
      if (t < last + 2) @(negedge clk);
    end
    check(bad == 0, tag, bt, 0);
  endtask

  task automatic t_reset;
    check(dior_n === 1 && diow_n === 1, "R1 strobes high", {dior_n, diow_n}, 2'b11);
    check(busy === 0 && done === 0, "R1 busy/done low", {busy, done}, 0);
    cfg_dev = 0; #1; check(cfg_rdata === 0, "R1 word0 zero", cfg_rdata, 0);
    cfg_dev = 1; #1; check(cfg_rdata === 0, "R1 word1 zero", cfg_rdata, 0);
  endtask

  task automatic t_data;
    logic [31:0] w = 32'h00084052;   // setup1 active5 inactive2
    wr_word(0, 0, w);
    run(0, 0, 0, 0, w, "R2 R3 R5 data read single");
    run(0, 1, 0, 0, w, "R7 data write single");
    run(0, 0, 0, 3, w, "R6 data read burst");
  endtask

  task automatic t_cmd;
    logic [31:0] w = 32'h00C37a00;   // cmd setup3 active7 inactive10
    wr_word(1, 0, w);
    run(1, 1, 1, 0, w, "R4 R5 command write");
    run(1, 0, 1, 2, w, "R4 R6 command read burst");
    w = 32'h00000000;                // all minimum, no setup
    wr_word(1, 0, w);
    run(0, 0, 1, 1, w, "R5 R2 zero setup minimum counts");
  endtask

  task automatic t_devsel;
    logic [31:0] w0 = 32'h00100031, w1 = 32'h00000f0f;
    wr_word(0, 0, w0); wr_word(1, 0, w1);
    run(0, 0, 1, 0, w1, "R8 device1 word");
    run(0, 0, 0, 0, w0, "R8 device0 word");
  endtask

  task automatic t_mask;
    logic [31:0] exp;
    for (int c = 1; c < 4; c++) begin
      wr_word(1, 0, 32'hFFFFFFFF);
      exp = upd(32'hFFFFFFFF, c[1:0], 32'h12345678);
      wr_word(1, c[1:0], 32'h12345678);
      cfg_dev = 1; #1;
      check(cfg_rdata === exp, "R9 masked update", cfg_rdata, exp);
    end
    wr_word(0, 0, 32'hC0000001);
    cfg_dev = 0; #1;
    check(cfg_rdata === 32'hC0000001, "R9 raw write keeps top bits", cfg_rdata, 32'hC0000001);
  endtask

  task automatic t_same_cycle;
    logic [31:0] wold = 32'h00083021, wnew = 32'h00000510;
    wr_word(0, 0, wold);
    cfg_we = 1; cfg_dev = 0; cfg_class = 0; cfg_wdata = wnew;
    run(0, 0, 0, 1, wold, "R10 write in accept cycle uses old word");
    cfg_dev = 0; #1;
    check(cfg_rdata === wnew, "R10 write landed", cfg_rdata, wnew);
    @(negedge clk);
    run(0, 0, 0, 0, wnew, "R10 next transfer uses new word");
  endtask

  task automatic t_mid_write;
    logic [31:0] wold = 32'h00104142, wnew = 32'h00000000;
    wr_word(1, 0, wold);
    fork
      run(0, 1, 1, 2, wold, "R10 mid-transfer write ignored");
      begin
        repeat (4) @(negedge clk);
        wr_word(1, 0, wnew);
      end
    join
    run(0, 1, 1, 0, wnew, "R10 later transfer uses rewritten word");
  endtask

  task automatic t_busy_req;
    logic [31:0] w = 32'h00082323;
    wr_word(0, 0, w);
    fork
      run(0, 0, 0, 1, w, "R12 R11 request while busy ignored");
      begin
        repeat (3) @(negedge clk);
        req = 1; req_beats = 4'd5;
        @(negedge clk);
        req = 0; req_beats = 4'd1;
      end
    join
    for (int k = 0; k < 6; k++) begin
      check(dior_n === 1 && busy === 0, "R12 stays idle", {dior_n, busy}, 2'b10);
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_data();
    t_cmd();
    t_devsel();
    t_mask();
    @(negedge clk);
    t_same_cycle();
    t_mid_write();
    t_busy_req();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule